// File: doc/BRIEF.md
# Half-Precision Sign-Injection and Register-Move Unit

This unit executes the half-precision sign-manipulation and raw register-move instructions of a core whose floating-point registers are 64 bits wide. It receives an already fetched instruction word, two floating-point source values and one integer source value. It returns either a 64-bit floating-point result or an integer result sized to the active integer width. With each result it returns a destination-select flag, an illegal-instruction flag and a one-cycle pulse that marks the floating-point state as modified.

A 16-bit value held in a 64-bit register is valid only when every bit above bit 15 is set. A source that fails this test is replaced by the canonical half NaN before it is used. Every floating-point result is returned with its upper 48 bits set. The block has one register stage: a result appears on the cycle after its valid input. A new instruction can be accepted on every cycle.

Top module: `half_sign_move_unit`

## Requirements
- R1: Each floating-point source of a sign-injection op with `fpA[63:16]` or `fpB[63:16]` not all ones is treated as `64'hFFFF_FFFF_FFFF_7E00` before use.
- R2: Sign-injection ops are recognised by `instr[6:0]=1010011` and `instr[31:25]=0010010`. `instr[14:12]` selects the form: 000 copy-sign, 001 negated-sign, 010 xor-sign.
- R3: Copy-sign returns the checked first source with bit 15 replaced by bit 15 of the checked second source.
- R4: Negated-sign returns the checked first source with bit 15 replaced by the inverse of bit 15 of the checked second source.
- R5: Xor-sign returns the checked first source with bit 15 set to the xor of both checked sources' bit 15.
- R6: When both sources hold the same value (equal register indices), the three forms give move, negate (bit 15 flipped) and absolute value (bit 15 cleared) of the checked source.
- R7: Move-to-integer (`instr[31:25]=1110010`, `instr[24:20]=0`, `instr[14:12]=000`) reads `fpA[15:0]` without a boxing check and sign-extends it.
  - With `xlen64=1` the extension fills all 64 bits of `intResult`.
  - With `xlen64=0` it fills bits 31:0 and bits 63:32 are zero.
  - `fpResult` is zero.
- R8: Move-to-float (`instr[31:25]=1111010`, `instr[24:20]=0`, `instr[14:12]=000`) returns `{48 ones, intA[15:0]}` on `fpResult`, and `intResult` is zero.
- R9: When `fpuOn` or `halfOn` is low, every instruction raises `illegal`, and `writesFp`, `fpDirty` and both results are zero.
- R10: Any other encoding raises `illegal` with both results zero. This covers another opcode, another funct7, funct3 011 to 111 under the sign-injection funct7, a nonzero `instr[24:20]` or nonzero funct3 on the move forms.
- R11: `writesFp` and `fpDirty` are high for one cycle for each legal op that writes a floating-point register. Both are low for move-to-integer. For each legal floating-point-writing op, `intResult` is zero.
- R12: Reset clears `outValid`, `illegal`, `writesFp`, `fpDirty` and both results.
  - `outValid` follows `inValid` by one cycle.
  - The three flags are low on any cycle where `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Instruction and operands are present |
| instr | input | 32 | Instruction word |
| fpA | input | 64 | First floating-point source |
| fpB | input | 64 | Second floating-point source |
| intA | input | 64 | Integer source |
| xlen64 | input | 1 | 1 selects 64-bit integer width, 0 selects 32-bit |
| fpuOn | input | 1 | Floating-point unit enabled |
| halfOn | input | 1 | Half-precision instructions enabled |
| outValid | output | 1 | Registered result valid |
| fpResult | output | 64 | Floating-point result |
| intResult | output | 64 | Integer result |
| writesFp | output | 1 | Result goes to the floating-point register file |
| illegal | output | 1 | Illegal-instruction indication |
| fpDirty | output | 1 | Floating-point state modified pulse |

## Verification
The block holds no state that lasts beyond one instruction, so a wrong decode or a wrong operand check shows on the very next cycle. It shows as a wrong flag combination or a wrong bit 15, or as a boxed value where a canonical NaN was due. Stale results from a previous op would appear as nonzero data on the unused result port. The reference model therefore compares both result ports and all flags on every cycle. The stimulus includes unboxed operands, a sign bit in both positions, both integer widths and every rejected encoding class.

// File: rtl/hsm_pkg.sv
package hsm_pkg;

  localparam logic [6:0] OPC_FP     = 7'b1010011;
  localparam logic [6:0] F7_SIGNINJ = 7'b0010010;
  localparam logic [6:0] F7_TO_INT  = 7'b1110010;
  localparam logic [6:0] F7_TO_FP   = 7'b1111010;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_SGNJ,
    OP_SGNJN,
    OP_SGNJX,
    OP_TO_INT,
    OP_TO_FP
  } hsmOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    hsmOp_e op;
    logic   writeFp;
    logic   markDirty;
    logic   illegal;
  } hsmStrobe_t;

endpackage

// File: rtl/hsm_ctrl.sv
module hsm_ctrl
  import hsm_pkg::*;
(
  input  logic [31:0] instr,
  input  logic        fpuOn,
  input  logic        halfOn,
  output hsmStrobe_t  strobe
);

  logic [6:0] opcode;
  logic [6:0] funct7;
  logic [4:0] srcSel2;
  logic [2:0] funct3;
  hsmOp_e     decOp;
  logic       enabled;
  logic       legal;

  assign opcode  = instr[6:0];
  assign funct3  = instr[14:12];
  assign srcSel2 = instr[24:20];
  assign funct7  = instr[31:25];
  assign enabled = fpuOn & halfOn;

  always_comb begin
    decOp = OP_NONE;
    if (opcode == OPC_FP) begin
      unique case (funct7)
        F7_SIGNINJ: begin
          unique case (funct3)
            3'b000:  decOp = OP_SGNJ;
            3'b001:  decOp = OP_SGNJN;
            3'b010:  decOp = OP_SGNJX;
            default: decOp = OP_NONE;
          endcase
        end
        F7_TO_INT: if (srcSel2 == 5'd0 && funct3 == 3'b000) decOp = OP_TO_INT;
        F7_TO_FP:  if (srcSel2 == 5'd0 && funct3 == 3'b000) decOp = OP_TO_FP;
        default:   decOp = OP_NONE;
      endcase
    end
  end

  assign legal = enabled && (decOp != OP_NONE);

  always_comb begin
    strobe.op        = legal ? decOp : OP_NONE;
    strobe.writeFp   = legal && (decOp != OP_TO_INT);
    strobe.markDirty = legal && (decOp != OP_TO_INT);
    strobe.illegal   = !legal;
  end

endmodule

// File: rtl/hsm_datapath.sv
module hsm_datapath
  import hsm_pkg::*;
#(
  parameter int FLEN     = 64,
  parameter int HALF_W   = 16,
  parameter int EXP_W    = 5,
  parameter int XLEN_MAX = 64,
  parameter int XLEN_MIN = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  hsmStrobe_t          strobe,
  input  logic [FLEN-1:0]     fpA,
  input  logic [FLEN-1:0]     fpB,
  input  logic [XLEN_MAX-1:0] intA,
  input  logic                xlen64,
  output logic                outValid,
  output logic [FLEN-1:0]     fpResult,
  output logic [XLEN_MAX-1:0] intResult,
  output logic                writesFp,
  output logic                illegal,
  output logic                fpDirty
);

  localparam int BOX_W  = FLEN - HALF_W;
  localparam int MANT_W = HALF_W - 1 - EXP_W;
  localparam int SIGN   = HALF_W - 1;
  localparam logic [FLEN-1:0] CANON_NAN =
    {{BOX_W{1'b1}}, 1'b0, {EXP_W{1'b1}}, 1'b1, {(MANT_W-1){1'b0}}};

  logic [FLEN-1:0] rawSrc [2];
  logic [FLEN-1:0] chkSrc [2];
  logic [FLEN-1:0] fpNext;
  logic [XLEN_MAX-1:0] intNext;
  logic [HALF_W-1:0] rawHalf;
  logic newSign;

  assign rawSrc[0] = fpA;
  assign rawSrc[1] = fpB;

  for (genvar g = 0; g < 2; g++) begin : g_boxCheck
    assign chkSrc[g] = (&rawSrc[g][FLEN-1:HALF_W]) ? rawSrc[g] : CANON_NAN;
  end

  assign rawHalf = fpA[HALF_W-1:0];

  always_comb begin
    newSign = chkSrc[0][SIGN];
    unique case (strobe.op)
      OP_SGNJ:  newSign = chkSrc[1][SIGN];
      OP_SGNJN: newSign = ~chkSrc[1][SIGN];
      OP_SGNJX: newSign = chkSrc[0][SIGN] ^ chkSrc[1][SIGN];
      default:  newSign = chkSrc[0][SIGN];
    endcase
  end

  always_comb begin
    fpNext  = '0;
    intNext = '0;
    unique case (strobe.op)
      OP_SGNJ, OP_SGNJN, OP_SGNJX:
        fpNext = {chkSrc[0][FLEN-1:SIGN+1], newSign, chkSrc[0][SIGN-1:0]};
      OP_TO_FP:
        fpNext = {{BOX_W{1'b1}}, intA[HALF_W-1:0]};
      OP_TO_INT:
        intNext = xlen64
          ? {{(XLEN_MAX-HALF_W){rawHalf[SIGN]}}, rawHalf}
          : {{(XLEN_MAX-XLEN_MIN){1'b0}}, {(XLEN_MIN-HALF_W){rawHalf[SIGN]}}, rawHalf};
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      illegal   <= 1'b0;
      writesFp  <= 1'b0;
      fpDirty   <= 1'b0;
      fpResult  <= '0;
      intResult <= '0;
    end else begin
      outValid <= inValid;
      illegal  <= inValid & strobe.illegal;
      writesFp <= inValid & strobe.writeFp;
      fpDirty  <= inValid & strobe.markDirty;
      if (inValid) begin
        fpResult  <= fpNext;
        intResult <= intNext;
      end
    end
  end

endmodule

// File: rtl/half_sign_move_unit.sv
module half_sign_move_unit
  import hsm_pkg::*;
#(
  parameter int FLEN     = 64,
  parameter int HALF_W   = 16,
  parameter int EXP_W    = 5,
  parameter int XLEN_MAX = 64,
  parameter int XLEN_MIN = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [31:0]         instr,
  input  logic [FLEN-1:0]     fpA,
  input  logic [FLEN-1:0]     fpB,
  input  logic [XLEN_MAX-1:0] intA,
  input  logic                xlen64,
  input  logic                fpuOn,
  input  logic                halfOn,
  output logic                outValid,
  output logic [FLEN-1:0]     fpResult,
  output logic [XLEN_MAX-1:0] intResult,
  output logic                writesFp,
  output logic                illegal,
  output logic                fpDirty
);

  hsmStrobe_t strobe;

  hsm_ctrl u_ctrl (
    .instr  (instr),
    .fpuOn  (fpuOn),
    .halfOn (halfOn),
    .strobe (strobe)
  );

  hsm_datapath #(
    .FLEN     (FLEN),
    .HALF_W   (HALF_W),
    .EXP_W    (EXP_W),
    .XLEN_MAX (XLEN_MAX),
    .XLEN_MIN (XLEN_MIN)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .strobe    (strobe),
    .fpA       (fpA),
    .fpB       (fpB),
    .intA      (intA),
    .xlen64    (xlen64),
    .outValid  (outValid),
    .fpResult  (fpResult),
    .intResult (intResult),
    .writesFp  (writesFp),
    .illegal   (illegal),
    .fpDirty   (fpDirty)
  );

endmodule

// File: rtl/half_sign_move_unit_chk.sv
module half_sign_move_unit_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        fpuOn,
  input logic        halfOn,
  input logic        outValid,
  input logic [63:0] fpResult,
  input logic [63:0] intResult,
  input logic        writesFp,
  input logic        illegal,
  input logic        fpDirty
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R12

  AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !(illegal || writesFp || fpDirty)); // R12

  AST_DIRTY_WITH_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    fpDirty |-> writesFp && !illegal); // R11

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> !writesFp && !fpDirty && fpResult == 64'd0 && intResult == 64'd0); // R10

  AST_DISABLED_TRAPS: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !(fpuOn && halfOn) |=> illegal); // R9

  AST_FP_BOXED: assert property (@(posedge clk) disable iff (!rstN)
    writesFp |-> fpResult[63:16] == 48'hFFFF_FFFF_FFFF); // R3

  AST_INT_SIGNEXT: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !writesFp && !illegal |-> intResult[31:16] == {16{intResult[15]}}); // R7

endmodule

bind half_sign_move_unit half_sign_move_unit_chk u_chk (.*);

// File: tb/half_sign_move_unit_bench.sv
module half_sign_move_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] fpA = '0, fpB = '0, intA = '0;
  logic        xlen64 = 1'b1, fpuOn = 1'b1, halfOn = 1'b1;
  logic        outValid, writesFp, illegal, fpDirty;
  logic [63:0] fpResult, intResult;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  half_sign_move_unit u_half_sign_move_unit (.*);

  function automatic logic [31:0] mk(input logic [6:0] f7, input logic [4:0] s2,
                                     input logic [4:0] s1, input logic [2:0] f3);
    return {f7, s2, s1, f3, 5'd3, 7'b1010011};
  endfunction

  // Behavioural reference: expected outputs one cycle after a valid input
  task automatic model(output logic eIll, output logic eWr, output logic [63:0] eFp,
                       output logic [63:0] eInt);
    logic [63:0] a, b;
    bit known;
    eIll = 1'b0; eWr = 1'b0; eFp = 0; eInt = 0; known = 0;
    a = fpA; b = fpB;
    if (a[63:16] != 48'hFFFF_FFFF_FFFF) a = 64'hFFFF_FFFF_FFFF_7E00;
    if (b[63:16] != 48'hFFFF_FFFF_FFFF) b = 64'hFFFF_FFFF_FFFF_7E00;
    if (instr[6:0] == 7'b1010011) begin
      if (instr[31:25] == 7'b0010010) begin
        known = 1;
        eFp = a;
        if (instr[14:12] == 3'd0)      eFp[15] = b[15];
        else if (instr[14:12] == 3'd1) eFp[15] = !b[15];
        else if (instr[14:12] == 3'd2) eFp[15] = a[15] ^ b[15];
        else known = 0;
        eWr = 1;
      end else if (instr[31:25] == 7'b1110010 && instr[24:20] == 0 && instr[14:12] == 0) begin
        known = 1;
        eInt = {{48{fpA[15]}}, fpA[15:0]};
        if (!xlen64) eInt[63:32] = 0;
      end else if (instr[31:25] == 7'b1111010 && instr[24:20] == 0 && instr[14:12] == 0) begin
        known = 1;
        eWr = 1;
        eFp = {48'hFFFF_FFFF_FFFF, intA[15:0]};
      end
    end
    if (!known || !fpuOn || !halfOn) begin
      eIll = 1; eWr = 0; eFp = 0; eInt = 0;
    end
  endtask

  task automatic cmp(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Drive one instruction, advance one clock, compare every output
  task automatic step(input string tag, input logic [31:0] ins, input logic [63:0] a,
                      input logic [63:0] b, input logic [63:0] ia);
    logic eIll, eWr;
    logic [63:0] eFp, eInt;
    inValid = 1; instr = ins; fpA = a; fpB = b; intA = ia;
    model(eIll, eWr, eFp, eInt);
    @(posedge clk);
    @(negedge clk);
    inValid = 0;
    cmp(tag, "outValid", {63'd0, outValid}, 64'd1);
    cmp(tag, "illegal", {63'd0, illegal}, {63'd0, eIll});
    cmp(tag, "writesFp", {63'd0, writesFp}, {63'd0, eWr});
    cmp(tag, "fpDirty", {63'd0, fpDirty}, {63'd0, eWr});
    cmp(tag, "fpResult", fpResult, eFp);
    cmp(tag, "intResult", intResult, eInt);
  endtask

  localparam logic [63:0] P1  = 64'hFFFF_FFFF_FFFF_3C00;
  localparam logic [63:0] N2  = 64'hFFFF_FFFF_FFFF_C000;
  localparam logic [63:0] UNB = 64'h0000_0000_0000_3C00;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp("R12", "reset outValid", {63'd0, outValid}, 64'd0);
    cmp("R12", "reset flags", {61'd0, illegal, writesFp, fpDirty}, 64'd0);
    cmp("R12", "reset results", fpResult | intResult, 64'd0);
    rstN = 1;
    @(negedge clk);

    step("R3", mk(7'b0010010, 5'd2, 5'd1, 3'd0), P1, N2, 0);
    step("R3", mk(7'b0010010, 5'd2, 5'd1, 3'd0), N2, P1, 0);
    step("R1", mk(7'b0010010, 5'd2, 5'd1, 3'd0), UNB, N2, 0);
    step("R1", mk(7'b0010010, 5'd2, 5'd1, 3'd0), N2, UNB, 0);
    step("R4", mk(7'b0010010, 5'd2, 5'd1, 3'd1), P1, N2, 0);
    step("R4", mk(7'b0010010, 5'd2, 5'd1, 3'd1), N2, P1, 0);
    step("R5", mk(7'b0010010, 5'd2, 5'd1, 3'd2), N2, N2 ^ 64'h8000, 0);
    step("R5", mk(7'b0010010, 5'd2, 5'd1, 3'd2), N2, N2, 0);
    step("R6", mk(7'b0010010, 5'd4, 5'd4, 3'd0), N2, N2, 0);
    step("R6", mk(7'b0010010, 5'd4, 5'd4, 3'd1), P1, P1, 0);
    step("R6", mk(7'b0010010, 5'd4, 5'd4, 3'd2), N2, N2, 0);
    step("R6", mk(7'b0010010, 5'd4, 5'd4, 3'd2), UNB, UNB, 0);
    step("R2", mk(7'b0010010, 5'd2, 5'd1, 3'd2), P1, N2, 0);

    xlen64 = 1;
    step("R7", mk(7'b1110010, 5'd0, 5'd1, 3'd0), 64'hFFFF_FFFF_FFFF_8001, 0, 0);
    step("R7", mk(7'b1110010, 5'd0, 5'd1, 3'd0), 64'h0000_0000_0000_ABCD, 0, 0);
    step("R11", mk(7'b1110010, 5'd0, 5'd1, 3'd0), 64'hFFFF_FFFF_FFFF_1234, 0, 0);
    xlen64 = 0;
    step("R7", mk(7'b1110010, 5'd0, 5'd1, 3'd0), 64'hFFFF_FFFF_FFFF_8001, 0, 0);
    step("R7", mk(7'b1110010, 5'd0, 5'd1, 3'd0), 64'hFFFF_FFFF_FFFF_7FFF, 0, 0);
    xlen64 = 1;

    step("R8", mk(7'b1111010, 5'd0, 5'd1, 3'd0), 0, 0, 64'hDEAD_BEEF_1234_5678);
    step("R8", mk(7'b1111010, 5'd0, 5'd1, 3'd0), 0, 0, 64'h0000_0000_0000_FFFF);

    fpuOn = 0;
    step("R9", mk(7'b0010010, 5'd2, 5'd1, 3'd0), P1, N2, 0);
    fpuOn = 1; halfOn = 0;
    step("R9", mk(7'b1111010, 5'd0, 5'd1, 3'd0), 0, 0, 64'h1234);
    step("R9", mk(7'b1110010, 5'd0, 5'd1, 3'd0), P1, 0, 0);
    halfOn = 1;

    for (int f = 3; f < 8; f++)
      step("R10", mk(7'b0010010, 5'd2, 5'd1, f[2:0]), P1, N2, 0);
    step("R10", mk(7'b1110010, 5'd1, 5'd1, 3'd0), P1, 0, 0);
    step("R10", mk(7'b1111010, 5'd0, 5'd1, 3'd1), 0, 0, 64'h55);
    step("R10", mk(7'b0010110, 5'd2, 5'd1, 3'd0), P1, N2, 0);
    step("R10", {mk(7'b0010010, 5'd2, 5'd1, 3'd0)} ^ 32'h4, P1, N2, 0);

    // Idle cycle: flags drop, results hold
    @(posedge clk);
    @(negedge clk);
    cmp("R12", "idle outValid", {63'd0, outValid}, 64'd0);
    cmp("R12", "idle flags", {61'd0, illegal, writesFp, fpDirty}, 64'd0);
    step("R11", mk(7'b0010010, 5'd2, 5'd1, 3'd1), P1, P1, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog: actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule